// File: doc/BRIEF.md
# SPI Word Queue Front End

This block is the register-facing half of an SPI master. Software writes transmit words into an eight-deep queue and reads received words out of a second eight-deep queue. Both operations use one shared data offset on a small 32-bit register bus. The block hands transmit words to the serial shift engine one at a time over a valid/take handshake. It accepts each received word from the engine as a single-cycle strobe. Serial timing itself belongs to the engine and is not modelled here.

Software sets a receive threshold. When the receive queue count climbs to that threshold, a latched completion flag is raised. A separate latched overrun flag records any word that arrived while the receive queue was full; that word is discarded. Each flag has its own enable bit, and the single interrupt line is the OR of the enabled flags. Both flags are cleared by writing ones to the interrupt status offset. Either queue can be emptied at once through a flush bit in the queue control register. Registers are decoded on byte address bits [5:2]; other offsets read as zero.

Top module: `spi_word_frontend`

## Requirements
- R1: After reset, every register reads zero, `irq` is 0 and `txValid` is 0.
- R2: The transmit queue holds 8 words in first-in first-out order. A write to the data offset (0x24) while it holds 8 words is ignored.
- R3: `txValid` is high only while the enable bit (bit 0 at offset 0x00) is 1 and the transmit queue is not empty. `txWord` is the oldest word. The word is removed in a cycle where `txValid` and `txTake` are both high.
- R4: A read of offset 0x24 returns the oldest received word and removes it. A read with the receive queue empty returns 0 and changes nothing.
- R5: Bit 0 of the status offset (0x14) is 1 exactly when the receive queue is not empty.
- R6: Bit 9 of the interrupt status offset (0x1C) reads 1 while the receive threshold is nonzero and the receive count is at least the threshold.
- R7: Bit 3 of offset 0x1C is a latched flag. It is set one cycle after the threshold condition of R6 becomes true, and it stays set until a write to 0x1C with bit 3 equal to 1. If a set and a clear fall in the same cycle, the set wins.
- R8: A received word that arrives while the receive queue holds 8 words is dropped. It sets the latched overrun flag, bit 0 of 0x1C, which is cleared by writing 1 to bit 0 of 0x1C.
- R9: `irq` is high while (bit 3 flag AND enable bit 3 at 0x18) OR (bit 0 flag AND enable bit 0 at 0x18).
- R10: The queue control offset (0x20) stores the transmit threshold in bits 11:8 and the receive threshold in bits 3:0, and both read back. Writing 1 to bit 12 empties the transmit queue, and writing 1 to bit 4 empties the receive queue. The flush bits read as 0.
- R11: The enable bit (bit 0 at offset 0x00) and the two interrupt enable bits (bits 3 and 0 at offset 0x18) read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register byte address |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe (pops data at 0x24) |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data, valid in the cycle `regRead` is high |
| irq | output | 1 | Interrupt request |
| txValid | output | 1 | A transmit word is offered to the shift engine |
| txWord | output | 32 | Oldest transmit word |
| txTake | input | 1 | Shift engine accepts the offered word |
| rxValid | input | 1 | Shift engine delivers a received word |
| rxWord | input | 32 | Received word |

## Verification
A wrong queue pointer or count shows up the first time the affected data offset is read or the engine takes a word: the order breaks, a word is lost or duplicated, or an empty read returns nonzero. A stuck or wrongly set flag shows up one cycle after the triggering receive edge, both in the interrupt status readback and on `irq`. A wrong threshold comparison flips bit 9 as soon as the receive count crosses the programmed value. Random bursts of up to eight words against random thresholds, together with directed full-queue, flush and masking cases, push each of these states to the ports within a few cycles.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 5;
  localparam int REG_IEN  = 6;
  localparam int REG_ISR  = 7;
  localparam int REG_FCTL = 8;
  localparam int REG_DATA = 9;

  localparam int BIT_DONE    = 3;
  localparam int BIT_OVR     = 0;
  localparam int BIT_REACHED = 9;
  localparam int BIT_TXFLUSH = 12;
  localparam int BIT_RXFLUSH = 4;

  typedef struct packed {
    logic enable;
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } strobe_t;
endpackage

// File: rtl/sqf_fifo.sv
module sqf_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wData,
  output logic [WIDTH-1:0] rData,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wPtr, rPtr;
  logic doPush, doPop, full;

  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full;
  assign doPop  = pop && (count != '0);
  assign rData  = mem[rPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wPtr] <= wData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wPtr  <= '0;
      rPtr  <= '0;
      count <= '0;
    end else begin
      if (doPush) wPtr <= nextPtr(wPtr);
      if (doPop)  rPtr <= nextPtr(rPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !flush) |=> (count == CNT_W'(DEPTH)));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
endmodule

// File: rtl/sqf_datapath.sv
module sqf_datapath
  import sqf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [WIDTH-1:0] busWData,
  input  logic             rxValid,
  input  logic [WIDTH-1:0] rxWord,
  input  logic             txTake,
  output logic             txValid,
  output logic [WIDTH-1:0] txWord,
  output logic [WIDTH-1:0] rxHead,
  output logic [CNT_W-1:0] rxCount
);
  logic [CNT_W-1:0] txCount;

  assign txValid = st.enable && (txCount != '0);

  sqf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) txQ (
    .clk(clk), .rstN(rstN), .push(st.txPush), .pop(txValid && txTake),
    .flush(st.txFlush), .wData(busWData), .rData(txWord), .count(txCount));

  sqf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) rxQ (
    .clk(clk), .rstN(rstN), .push(rxValid), .pop(st.rxPop),
    .flush(st.rxFlush), .wData(rxWord), .rData(rxHead), .count(rxCount));

  // R3
  offer_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txTake && !st.txFlush) |=> $stable(txWord));
endmodule

// File: rtl/sqf_control.sv
module sqf_control
  import sqf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 6,
  parameter int THR_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [WIDTH-1:0]  regWData,
  output logic [WIDTH-1:0]  regRData,
  output logic              irq,
  output strobe_t           st,
  input  logic              rxValid,
  input  logic [WIDTH-1:0]  rxHead,
  input  logic [CNT_W-1:0]  rxCount
);
  logic [ADDR_W-3:0] idx;
  logic ctrlEn, ienDone, ienOvr, doneFlag, ovrFlag, reached, reachedQ;
  logic [THR_W-1:0] rxThr, txThr;
  logic wrIsr, rxEmpty, rxFull;
  logic unusedAddr;

  assign idx        = regAddr[ADDR_W-1:2];
  assign unusedAddr = ^regAddr[1:0];
  assign rxEmpty    = (rxCount == '0);
  assign rxFull     = (rxCount == CNT_W'(DEPTH));
  assign wrIsr      = regWrite && (idx == (ADDR_W-2)'(REG_ISR));
  assign reached    = (rxThr != '0) && (CMP_W'(rxCount) >= CMP_W'(rxThr));

  always_comb begin
    st.enable  = ctrlEn;
    st.txPush  = regWrite && (idx == (ADDR_W-2)'(REG_DATA));
    st.rxPop   = regRead && (idx == (ADDR_W-2)'(REG_DATA));
    st.txFlush = regWrite && (idx == (ADDR_W-2)'(REG_FCTL)) && regWData[BIT_TXFLUSH];
    st.rxFlush = regWrite && (idx == (ADDR_W-2)'(REG_FCTL)) && regWData[BIT_RXFLUSH];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlEn <= 1'b0; ienDone <= 1'b0; ienOvr <= 1'b0;
      rxThr <= '0; txThr <= '0;
      doneFlag <= 1'b0; ovrFlag <= 1'b0; reachedQ <= 1'b0;
    end else begin
      reachedQ <= reached;
      if (regWrite) begin
        if (idx == (ADDR_W-2)'(REG_CTRL)) ctrlEn <= regWData[0];
        if (idx == (ADDR_W-2)'(REG_IEN)) begin
          ienDone <= regWData[BIT_DONE];
          ienOvr  <= regWData[BIT_OVR];
        end
        if (idx == (ADDR_W-2)'(REG_FCTL)) begin
          rxThr <= regWData[THR_W-1:0];
          txThr <= regWData[8 +: THR_W];
        end
      end
      if (reached && !reachedQ)          doneFlag <= 1'b1;
      else if (wrIsr && regWData[BIT_DONE]) doneFlag <= 1'b0;
      if (rxValid && rxFull)             ovrFlag <= 1'b1;
      else if (wrIsr && regWData[BIT_OVR]) ovrFlag <= 1'b0;
    end
  end

  assign irq = (doneFlag && ienDone) || (ovrFlag && ienOvr);

  always_comb begin
    regRData = '0;
    if (regRead) begin
      case (idx)
        (ADDR_W-2)'(REG_CTRL): regRData[0] = ctrlEn;
        (ADDR_W-2)'(REG_STAT): regRData[0] = !rxEmpty;
        (ADDR_W-2)'(REG_IEN): begin
          regRData[BIT_DONE] = ienDone;
          regRData[BIT_OVR]  = ienOvr;
        end
        (ADDR_W-2)'(REG_ISR): begin
          regRData[BIT_REACHED] = reached;
          regRData[BIT_DONE]    = doneFlag;
          regRData[BIT_OVR]     = ovrFlag;
        end
        (ADDR_W-2)'(REG_FCTL): begin
          regRData[THR_W-1:0]  = rxThr;
          regRData[8 +: THR_W] = txThr;
        end
        (ADDR_W-2)'(REG_DATA): regRData = rxEmpty ? '0 : rxHead;
        default: regRData = '0;
      endcase
    end
  end

  // R7
  done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reached && !reachedQ) |=> doneFlag);
  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxFull) |=> ovrFlag);
  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.rxPop && rxEmpty && !rxValid) |=> rxEmpty);
endmodule

// File: rtl/spi_word_frontend.sv
module spi_word_frontend
  import sqf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic              regRead,
  input  logic [WIDTH-1:0]  regWData,
  output logic [WIDTH-1:0]  regRData,
  output logic              irq,
  output logic              txValid,
  output logic [WIDTH-1:0]  txWord,
  input  logic              txTake,
  input  logic              rxValid,
  input  logic [WIDTH-1:0]  rxWord
);
  strobe_t          st;
  logic [WIDTH-1:0] rxHead;
  logic [CNT_W-1:0] rxCount;

  sqf_control #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regRead(regRead), .regWData(regWData), .regRData(regRData), .irq(irq),
    .st(st), .rxValid(rxValid), .rxHead(rxHead), .rxCount(rxCount));

  sqf_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dp (
    .clk(clk), .rstN(rstN), .st(st), .busWData(regWData), .rxValid(rxValid),
    .rxWord(rxWord), .txTake(txTake), .txValid(txValid), .txWord(txWord),
    .rxHead(rxHead), .rxCount(rxCount));
endmodule

// File: tb/spi_word_frontend_test.sv
module spi_word_frontend_test;
  logic clk = 0, rstN = 0;
  logic [5:0] regAddr = '0;
  logic regWrite = 0, regRead = 0, txTake = 0, rxValid = 0;
  logic [31:0] regWData = '0, rxWord = '0, regRData, txWord;
  logic irq, txValid;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] q[$];

  spi_word_frontend uut (.*);

  always #2 clk = ~clk;

  function automatic logic [31:0] expIsr(int n, int thr);
    return (thr != 0 && n >= thr) ? 32'h208 : 32'h0;
  endfunction
  function automatic logic [31:0] expFctl(int tx, int rx);
    return (32'(tx) << 8) | 32'(rx);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    regAddr = a; regWData = d; regWrite = 1;
    @(negedge clk);
    regWrite = 0;
  endtask
  task automatic rd(logic [5:0] a, output logic [31:0] d);
    regAddr = a; regRead = 1;
    #1 d = regRData;
    @(negedge clk);
    regRead = 0;
  endtask
  task automatic rxPush(logic [31:0] w);
    rxWord = w; rxValid = 1;
    @(negedge clk);
    rxValid = 0;
  endtask
  task automatic take(string tag, logic [31:0] exp);
    chk(tag, {31'b0, txValid}, 32'h1);
    chk(tag, txWord, exp);
    txTake = 1;
    @(negedge clk);
    txTake = 0;
  endtask
  task automatic drainRx(string tag);
    logic [31:0] d;
    while (q.size() > 0) begin
      rd(6'h24, d);
      chk(tag, d, q.pop_front());
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] w[9];
    void'($urandom(32'd7071));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 txValid", {31'b0, txValid}, 0);
    rd(6'h00, d); chk("R1 ctrl", d, 0);
    rd(6'h14, d); chk("R1 status", d, 0);
    rd(6'h1C, d); chk("R1 isr", d, 0);
    rd(6'h20, d); chk("R1 fctl", d, 0);
    rd(6'h24, d); chk("R1 data", d, 0);

    // R2 R3: fill 9 words while disabled
    for (int i = 0; i < 9; i++) begin
      w[i] = $urandom;
      wr(6'h24, w[i]);
    end
    chk("R3 disabled", {31'b0, txValid}, 0);
    wr(6'h00, 1);
    rd(6'h00, d); chk("R11 ctrl", d, 1);
    for (int i = 0; i < 8; i++) take("R2 order", w[i]);
    chk("R2 ninth dropped", {31'b0, txValid}, 0);

    // R10 R6 R7 R9: thresholds and completion
    wr(6'h20, expFctl(5, 3));
    rd(6'h20, d); chk("R10 readback", d, expFctl(5, 3));
    wr(6'h18, 32'h9);
    rd(6'h18, d); chk("R11 ien", d, 32'h9);
    for (int i = 0; i < 2; i++) begin d = $urandom; q.push_back(d); rxPush(d); end
    @(negedge clk);
    rd(6'h1C, d); chk("R6 below", d, expIsr(2, 3));
    rd(6'h14, d); chk("R5 nonempty", d, 1);
    d = $urandom; q.push_back(d); rxPush(d);
    @(negedge clk);
    rd(6'h1C, d); chk("R7 set", d, expIsr(3, 3));
    chk("R9 irq", {31'b0, irq}, 1);
    drainRx("R4 order");
    rd(6'h14, d); chk("R5 empty", d, 0);
    rd(6'h24, d); chk("R4 empty read", d, 0);
    rd(6'h1C, d); chk("R7 latched", d, 32'h8);
    wr(6'h1C, 32'h8);
    rd(6'h1C, d); chk("R7 cleared", d, 0);
    chk("R9 irq low", {31'b0, irq}, 0);

    // R8 overrun
    for (int i = 0; i < 9; i++) begin
      d = $urandom;
      if (i < 8) q.push_back(d);
      rxPush(d);
    end
    @(negedge clk);
    rd(6'h1C, d); chk("R8 flags", d, 32'h209);
    wr(6'h18, 0);
    chk("R9 masked", {31'b0, irq}, 0);
    wr(6'h18, 32'h1);
    chk("R9 ovr only", {31'b0, irq}, 1);
    drainRx("R8 kept");
    rd(6'h24, d); chk("R8 dropped", d, 0);
    wr(6'h1C, 32'h9);
    rd(6'h1C, d); chk("R8 cleared", d, 0);
    chk("R9 irq clear", {31'b0, irq}, 0);
    wr(6'h18, 32'h9);

    // R10 flushes
    for (int i = 0; i < 4; i++) rxPush($urandom);
    wr(6'h20, expFctl(5, 3) | 32'h10);
    rd(6'h14, d); chk("R10 rx flush", d, 0);
    rd(6'h20, d); chk("R10 flush bits", d, expFctl(5, 3));
    rd(6'h24, d); chk("R10 rx empty", d, 0);
    wr(6'h1C, 32'h9);
    wr(6'h00, 0);
    for (int i = 0; i < 3; i++) wr(6'h24, $urandom);
    wr(6'h20, expFctl(5, 3) | 32'h1000);
    wr(6'h00, 1);
    chk("R10 tx flush", {31'b0, txValid}, 0);
    d = $urandom; wr(6'h24, d);
    take("R3 after flush", d);

    // random bursts
    for (int it = 0; it < 40; it++) begin
      int thr, n, m;
      thr = int'($urandom % 8) + 1;
      n = int'($urandom % 8) + 1;
      m = int'($urandom % 8) + 1;
      wr(6'h20, expFctl(0, thr));
      wr(6'h1C, 32'h9);
      for (int i = 0; i < n; i++) begin d = $urandom; q.push_back(d); rxPush(d); end
      @(negedge clk);
      rd(6'h1C, d); chk("R6 R7 random", d, expIsr(n, thr));
      chk("R9 random", {31'b0, irq}, (n >= thr) ? 32'h1 : 32'h0);
      drainRx("R4 random");
      rd(6'h14, d); chk("R5 random", d, 0);
      for (int i = 0; i < m; i++) begin w[i] = $urandom; wr(6'h24, w[i]); end
      for (int i = 0; i < m; i++) take("R3 random", w[i]);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule